// File: doc/BRIEF.md
# Cascadable Presettable Binary Counter

This block is a chain of identical four-bit synchronous up-counter slices that together form one wide binary counter. Every slice has an asynchronous active-low clear, a synchronous active-low parallel preset and two count enables. One enable is a plain gate that every slice shares. The other, the trickle enable, also qualifies the slice's terminal-count carry. A slice's carry feeds the trickle enable of the next more significant slice, so the whole chain counts as one binary number and needs no extra gating between slices.

The preset takes priority over both enables. Clear overrides everything, including the clock. The count bus is the register contents with no added delay. The top-level carry output signals that every slice sits at its maximum while the chain's trickle enable is high. That carry can feed the trickle enable of a further chain.

The block moves no data stream. All of its pins are plain control or status levels, so there is no valid/ready handshake and no back-pressure.

Top module: `ctr_cascade`

## Requirements
- R1: While `clear_n` is low, every count bit reads 0 at once, without waiting for a clock edge. This holds whatever the levels of `load_n`, `en_par` and `en_trk`, and clear wins when clear and preset are both low.
- R2: With `clear_n` high and `load_n` low, the next rising edge of `clk` copies `load_val` into `count`, whatever the levels of the enables.
- R3: With `clear_n` and `load_n` high and both `en_par` and `en_trk` high, each rising edge adds one to the full-width `count`.
- R4: With `load_n` high and either enable low, `count` holds its value. Levels that `load_n`, `en_par` or `en_trk` take between edges and remove again before the next rising edge leave `count` unchanged.
- R5: A slice's carry is high exactly when its trickle enable is high and its four bits are all ones (value 15). The trickle enable of slice 0 is `en_trk`.
- R6: A slice at 15 that counts goes to 0, and the slice above it advances on the same edge. A carry can pass through several slices in one edge (for example 0x0FF becomes 0x100).
- R7: `carry_out` is high exactly when `en_trk` is high and every bit of `count` is 1. `en_par` has no effect on it.
- R8: Bit 0 of `load_val` and of `count` is the least significant bit. Slice k holds bits 4k+3 down to 4k.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock shared by all slices |
| clear_n | input | 1 | Asynchronous clear, active low |
| load_n | input | 1 | Synchronous preset, active low |
| en_par | input | 1 | Count enable shared by all slices |
| en_trk | input | 1 | Trickle enable of slice 0; also gates carries |
| load_val | input | STAGE_W*STAGES (12) | Preset value, bit 0 least significant |
| count | output | STAGE_W*STAGES (12) | Current count |
| carry_out | output | 1 | Terminal-count carry of the most significant slice |

## Verification
The hardest situation to reach from the ports is a carry that passes through more than one slice on a single edge, together with a clear that lands between two edges while a preset is pending. The stimulus presets values such as 0x0EF, 0x0FF and 0xFFD and then counts across them. To exercise the clear, it lowers `clear_n` halfway through a cycle and samples `count` before the next edge, then holds clear against a low `load_n` over an edge. Enable and preset pulses that rise and fall between edges are also applied, to show they leave no trace.

// File: rtl/ctr_pkg.sv
package ctr_pkg;

  typedef enum logic [1:0] {
    OP_HOLD   = 2'd0,
    OP_STEP   = 2'd1,
    OP_PRESET = 2'd2
  } ctr_op_e;

endpackage

// File: rtl/ctr_op_decode.sv
module ctr_op_decode
  import ctr_pkg::*;
(
  input  logic    load_n,
  input  logic    en_par,
  input  logic    en_trk,
  output ctr_op_e op
);

  // preset outranks both enables; counting needs both enables
  always_comb begin
    if (!load_n)
      op = OP_PRESET;
    else if (en_par && en_trk)
      op = OP_STEP;
    else
      op = OP_HOLD;
  end

endmodule

// File: rtl/ctr_slice.sv
module ctr_slice
  import ctr_pkg::*;
#(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         clear_n,
  input  logic         load_n,
  input  logic         en_par,
  input  logic         en_trk,
  input  logic [W-1:0] din,
  output logic [W-1:0] q,
  output logic         carry
);

  localparam logic [W-1:0] MAXV = {W{1'b1}};

  ctr_op_e op;

  ctr_op_decode u_dec (
    .load_n (load_n),
    .en_par (en_par),
    .en_trk (en_trk),
    .op     (op)
  );

  always_ff @(posedge clk or negedge clear_n) begin
    if (!clear_n)
      q <= '0;
    else begin
      case (op)
        OP_PRESET: q <= din;
        OP_STEP:   q <= q + 1'b1;
        default:   q <= q;
      endcase
    end
  end

  assign carry = en_trk & (q == MAXV);

  // R1: clear forces zero
  always @(posedge clk) begin
    if (!clear_n) begin
      p_clear_zero_r1: assert (q == '0);
    end
  end

  p_preset_r2: assert property (@(posedge clk) disable iff (!clear_n)
    !load_n |=> q == $past(din));

  p_step_r3: assert property (@(posedge clk) disable iff (!clear_n)
    (load_n && en_par && en_trk) |=> q == $past(q) + 1'b1);

  p_hold_r4: assert property (@(posedge clk) disable iff (!clear_n)
    (load_n && !(en_par && en_trk)) |=> $stable(q));

  p_wrap_r6: assert property (@(posedge clk) disable iff (!clear_n)
    (load_n && en_par && en_trk && q == MAXV) |=> q == '0);

endmodule

// File: rtl/ctr_cascade.sv
module ctr_cascade #(
  parameter int STAGE_W = 4,
  parameter int STAGES  = 3
) (
  input  logic                         clk,
  input  logic                         clear_n,
  input  logic                         load_n,
  input  logic                         en_par,
  input  logic                         en_trk,
  input  logic [STAGE_W*STAGES-1:0]    load_val,
  output logic [STAGE_W*STAGES-1:0]    count,
  output logic                         carry_out
);

  localparam int TOTAL_W = STAGE_W * STAGES;

  // trk[k] is the trickle enable of slice k; trk[STAGES] is the final carry
  logic [STAGES:0] trk;

  assign trk[0] = en_trk;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    ctr_slice #(.W(STAGE_W)) u_slice (
      .clk     (clk),
      .clear_n (clear_n),
      .load_n  (load_n),
      .en_par  (en_par),
      .en_trk  (trk[g]),
      .din     (load_val[g*STAGE_W +: STAGE_W]),
      .q       (count[g*STAGE_W +: STAGE_W]),
      .carry   (trk[g+1])
    );
  end

  assign carry_out = trk[STAGES];

  p_carry_full_r7: assert property (@(posedge clk) disable iff (!clear_n)
    carry_out |-> (en_trk && count == {TOTAL_W{1'b1}}));

  p_chain_step_r6: assert property (@(posedge clk) disable iff (!clear_n)
    (load_n && en_par && en_trk) |=> count == $past(count) + 1'b1);

  p_slice0_carry_r5: assert property (@(posedge clk) disable iff (!clear_n)
    trk[1] |-> (en_trk && count[STAGE_W-1:0] == {STAGE_W{1'b1}}));

endmodule

// File: tb/sim_ctr_cascade.sv
`timescale 1ns/1ps
module sim_ctr_cascade;

  localparam int TW = 12;

  logic          clk = 1'b0;
  logic          clear_n = 1'b0;
  logic          load_n = 1'b1;
  logic          en_par = 1'b0;
  logic          en_trk = 1'b0;
  logic [TW-1:0] load_val = '0;
  logic [TW-1:0] count;
  logic          carry_out;

  int total = 0;
  int bad = 0;
  logic [TW-1:0] model = '0;
  logic [TW:0]   exp_q [$];
  string         tag_q [$];
  bit            done = 1'b0;

  always #2.5 clk = ~clk;

  ctr_cascade #(.STAGE_W(4), .STAGES(3)) u0 (
    .clk (clk), .clear_n (clear_n), .load_n (load_n), .en_par (en_par),
    .en_trk (en_trk), .load_val (load_val), .count (count), .carry_out (carry_out)
  );

  task automatic check(input string tag, input logic [TW:0] act, input logic [TW:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual carry=%0b count=%03h expected carry=%0b count=%03h",
               tag, act[TW], act[TW-1:0], exp[TW], exp[TW-1:0]);
    end
  endtask

  // driver: set inputs at falling edge, push expected result of next rising edge
  task automatic step(input logic clr, input logic ld, input logic ep,
                      input logic et, input logic [TW-1:0] d, input string tag);
    @(negedge clk);
    clear_n = clr; load_n = ld; en_par = ep; en_trk = et; load_val = d;
    if (!clr)               model = '0;
    else if (!ld)           model = d;
    else if (ep && et)      model = model + 1'b1;
    exp_q.push_back({et && clr && (&model), model});
    tag_q.push_back(tag);
  endtask

  // monitor: compare shortly after each rising edge
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      logic [TW:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(t, {carry_out, count}, e);
    end
  end

  initial begin
    #1;
    check("R1 reset state", {carry_out, count}, '0);
    step(0, 0, 1, 1, 12'h777, "R1 clear beats preset");
    step(1, 0, 0, 0, 12'h00C, "R2 preset with enables low");
    step(1, 1, 1, 1, '0, "R3 count 13");
    step(1, 1, 1, 1, '0, "R3 count 14");
    step(1, 1, 1, 1, '0, "R5 slice0 at 15");
    step(1, 1, 1, 1, '0, "R6 wrap into slice1");
    step(1, 1, 1, 1, '0, "R3 count after wrap");
    step(1, 1, 1, 1, '0, "R8 value 0x012");
    step(1, 1, 0, 1, 12'hABC, "R4 hold en_par low");
    step(1, 1, 1, 0, '0, "R4 hold en_trk low");
    // pulses between edges that vanish before the rising edge
    step(1, 1, 0, 0, 12'h3C3, "R4 hold both low");
    #0.5; load_n = 0; en_par = 1; en_trk = 1;
    #0.5; load_n = 1; en_par = 0; en_trk = 0;
    step(1, 0, 1, 1, 12'hFFD, "R2 preset with enables high");
    step(1, 1, 1, 1, '0, "R3 count FFE");
    step(1, 1, 1, 1, '0, "R7 carry at FFF");
    step(1, 1, 1, 1, '0, "R6 full wrap to 000");
    step(1, 0, 0, 1, 12'hFFF, "R7 carry with en_par low");
    step(1, 1, 1, 0, '0, "R7 no carry with en_trk low");
    step(1, 0, 0, 0, 12'h0EF, "R2 preset 0EF");
    step(1, 1, 1, 1, '0, "R6 carry slice0 to slice1");
    step(1, 0, 0, 0, 12'h0FF, "R2 preset 0FF");
    step(1, 1, 1, 1, '0, "R6 carry through two slices");
    step(1, 0, 0, 0, 12'hF0F, "R5 slice0 max, upper not");
    step(1, 1, 1, 1, '0, "R6 F10 after count");
    // clear asserted mid-cycle
    @(negedge clk);
    #1; clear_n = 0;
    #0.5;
    check("R1 async clear mid-cycle", {carry_out, count}, '0);
    model = '0;
    step(0, 0, 1, 1, 12'h5A5, "R1 clear held over edge");
    step(1, 0, 0, 0, 12'h5A5, "R8 bit order 5A5");
    step(1, 1, 1, 1, '0, "R3 count 5A6");
    step(1, 1, 1, 1, '0, "R3 count 5A7");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        #(200000 * 5);
        total++; bad++;
        $display("FAIL watchdog: actual=hung expected=done");
      end
    join_any
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule